// File: doc/BRIEF.md
# PHY Boot Sequencer

This block brings a combined USB and DisplayPort PHY from reset to a usable state under hardware control. A single start pulse launches a fixed sequence. The sequencer holds the PHY and lane 0 in reset, parks the four DisplayPort transmit lanes, turns on power and selects the boot mode. It then waits out two timed windows and releases the resets. After that it clocks the configuration-register (CR) clock in bursts until the PHY's SRAM is ready.

In RAM boot mode it writes two fixed override values and then streams a firmware table, one CR write per entry. It then hands the SRAM to the PHY's internal engines and clocks again until initialisation completes. In ROM boot mode the table load and the hand-over are skipped.

Both modes end with a bounded poll of a receive-lane calibration flag, followed by a read-modify-write of the transmit swing register. The result appears as a sticky ready or error flag. All delays count a one-microsecond tick input, so the timing does not depend on the system clock frequency. The CR bus itself sits outside this block and is reached through a request/done handshake.

The sequence runs through these states:

- IDLE.
- RESET (asserts the PHY and lane resets) → POWER → REXT_WAIT → HOLD_WAIT.
- SRAM_TOGGLE ⇄ SRAM_CHECK. SRAM_CHECK goes to PRELOAD0 in RAM mode, or straight to CAL_READ in ROM mode.
- PRELOAD0 → PRELOAD1 → FW_WRITE (repeated once per table entry) → LOAD_RISE → LOAD_HOLD.
- INIT_TOGGLE ⇄ INIT_CHECK → CAL_READ.
- CAL_READ → CAL_GAP → CAL_READ, repeated until the flag is seen. CAL_READ then goes to SWING_READ, or to FAILED once the try limit is spent.
- SWING_READ → SWING_WRITE → DONE.

A new start is accepted only in IDLE, DONE or FAILED.

Top module: `phy_boot_seq`

## Requirements
- R1: After reset, the following outputs are low: ready, error, cr_req, phy_rst, lane0_rst, ext_ld_done and cr_clk. test_pd is high.
- R2: An accepted start does two things. First, phy_rst, lane0_rst, all dp_tx_dis bits and all dp_tx_rst bits go high. Second, ana_pwr_en goes high, test_pd low, cr_sel high and ext_ld_done low. sram_bypass is set to use_rom: 1 for ROM mode, 0 for RAM mode.
- R3: At least REXT_US ticks pass after power-up. Then lane_flip is written as 3'd4 for port 1 or 3'd0 for port 0. At least HOLD_US further ticks pass, after which phy_rst and lane0_rst fall in the same cycle. The reset window therefore spans at least REXT_US+HOLD_US ticks.
- R4: After reset release, cr_clk is pulsed in bursts of SRAM_BURST pulses, and sram_init_done is sampled after each burst. The pulse count before the next step is SRAM_BURST times the number of bursts, and at least one burst always runs.
- R5: RAM mode writes 16'h8000 to CR address 16'h31C5 and then to 16'h32C5. It then writes every table entry from index 0 to fw_len-1 in order, one write per entry. When fw_len is 0, no entry is written.
- R6: After the table load, cr_clk goes high and ext_ld_done is set while cr_clk is high. cr_clk is then pulsed in bursts of INIT_BURST until init_done is seen.
- R7: ROM mode makes no preload or table writes, and ext_ld_done stays low.
- R8: The calibration poll reads CR address 16'h303E plus a receive offset: 16'h0100 for port 0 or 16'h0200 for port 1. It tests bit 1 of the read data. Successive reads are at least POLL_US ticks apart. After POLL_TRIES reads with bit 1 clear, error is set.
- R9: Once calibration succeeds, the sequencer reads CR address 16'h0022. It writes back the read value with bits 6:4 set to 7 and bit 7 set, then sets ready.
- R10: ready and error are never both high. Each stays set until the next accepted start. A start during a running sequence is ignored.
- R11: cr_req stays high, with cr_addr, cr_we and cr_wdata unchanged, until a cycle in which cr_done is high. cr_we is 1 for writes and 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| start | input | 1 | Begin the boot sequence |
| use_rom | input | 1 | 1 selects ROM boot, 0 selects RAM boot |
| port_sel | input | 1 | PHY port in use (0 or 1) |
| fw_len | input | FW_IDX_W+1 | Number of firmware table entries |
| fw_idx | output | FW_IDX_W | Firmware table read index |
| fw_addr | input | 16 | CR address of the indexed table entry |
| fw_data | input | 16 | CR data of the indexed table entry |
| cr_req | output | 1 | CR access request |
| cr_we | output | 1 | CR access is a write |
| cr_addr | output | 16 | CR access address |
| cr_wdata | output | 16 | CR write data |
| cr_rdata | input | 16 | CR read data, valid with cr_done |
| cr_done | input | 1 | CR access complete |
| cr_clk | output | 1 | CR clock driven during the boot waits |
| sram_init_done | input | 1 | PHY SRAM ready for loading |
| init_done | input | 1 | PHY initialisation finished after load |
| phy_rst | output | 1 | PHY reset |
| lane0_rst | output | 1 | Lane 0 reset |
| dp_tx_dis | output | 4 | DisplayPort transmit lane disables |
| dp_tx_rst | output | 4 | DisplayPort transmit lane resets |
| ana_pwr_en | output | 1 | Analog power enable |
| test_pd | output | 1 | Test power-down |
| cr_sel | output | 1 | CR clock source select |
| ext_ld_done | output | 1 | External SRAM load complete |
| sram_bypass | output | 1 | Boot from ROM, bypassing SRAM |
| lane_flip | output | 3 | Lane orientation configuration |
| ready | output | 1 | Sequence completed (sticky) |
| error | output | 1 | Calibration poll exhausted (sticky) |

## Verification
The assertions check four properties on every cycle:
- the CR request is held steady until it completes;
- ready and error are exclusive, and ready stays set until the next start;
- the two resets are released together, ext_ld_done rises only while cr_clk is high, and a ROM boot issues no write other than the swing update;
- the poll counter never passes its limit.

Only the bench scenarios can show the end-to-end behaviour. These include the exact order and content of the CR transactions and the pulse counts that follow from the SRAM and init readiness thresholds. They also cover the lane-flip and receive-offset choices for each port, the spacing of the poll reads, the error after the last failed try, and a start pulse that is ignored mid-sequence.

// File: rtl/boot_pkg.sv
package boot_pkg;
    localparam int CR_W = 16;

    localparam logic [CR_W-1:0] PRELOAD_A0   = 16'h31C5;
    localparam logic [CR_W-1:0] PRELOAD_A1   = 16'h32C5;
    localparam logic [CR_W-1:0] PRELOAD_VAL  = 16'h8000;
    localparam logic [CR_W-1:0] CAL_BASE     = 16'h303E;
    localparam logic [CR_W-1:0] SWING_ADDR   = 16'h0022;
    localparam logic [CR_W-1:0] RX_OFF_P0    = 16'h0100;
    localparam logic [CR_W-1:0] RX_OFF_P1    = 16'h0200;
    localparam logic [CR_W-1:0] SWING_CLR    = 16'h0070;
    localparam logic [CR_W-1:0] SWING_SET    = 16'h00F0;
    localparam logic [2:0]      FLIP_PORT1   = 3'd4;

    typedef enum logic [4:0] {
        S_IDLE, S_RESET, S_POWER, S_REXT, S_HOLD,
        S_SRAM_TG, S_SRAM_CHK, S_PRE0, S_PRE1, S_FW,
        S_LD_RISE, S_LD_HOLD, S_INIT_TG, S_INIT_CHK,
        S_CAL_RD, S_CAL_GAP, S_SW_RD, S_SW_WR, S_DONE, S_FAILED
    } boot_state_e;
endpackage

// File: rtl/boot_us_timer.sv
module boot_us_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (tick && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/boot_clk_burst.sv
module boot_clk_burst #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] half_len,
    output logic         tg,
    output logic         last
);
    logic [W-1:0] hc;

    assign last = run && (hc == half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc <= '0;
            tg <= 1'b0;
        end else if (!run) begin
            hc <= '0;
            tg <= 1'b0;
        end else begin
            tg <= ~tg;
            hc <= last ? '0 : hc + 1'b1;
        end
    end
endmodule

// File: rtl/boot_lane_addr.sv
module boot_lane_addr
    import boot_pkg::*;
(
    input  logic            port,
    input  logic [CR_W-1:0] base,
    output logic [CR_W-1:0] rx_addr
);
    assign rx_addr = base + (port ? RX_OFF_P1 : RX_OFF_P0);
endmodule

// File: rtl/phy_boot_seq.sv
module phy_boot_seq
    import boot_pkg::*;
#(
    parameter int REXT_US    = 10,
    parameter int HOLD_US    = 20,
    parameter int POLL_US    = 1000,
    parameter int POLL_TRIES = 100,
    parameter int SRAM_BURST = 10,
    parameter int INIT_BURST = 8,
    parameter int FW_IDX_W   = 8,
    parameter int DP_LANES   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                us_tick,
    input  logic                start,
    input  logic                use_rom,
    input  logic                port_sel,
    input  logic [FW_IDX_W:0]   fw_len,
    output logic [FW_IDX_W-1:0] fw_idx,
    input  logic [15:0]         fw_addr,
    input  logic [15:0]         fw_data,
    output logic                cr_req,
    output logic                cr_we,
    output logic [15:0]         cr_addr,
    output logic [15:0]         cr_wdata,
    input  logic [15:0]         cr_rdata,
    input  logic                cr_done,
    output logic                cr_clk,
    input  logic                sram_init_done,
    input  logic                init_done,
    output logic                phy_rst,
    output logic                lane0_rst,
    output logic [DP_LANES-1:0] dp_tx_dis,
    output logic [DP_LANES-1:0] dp_tx_rst,
    output logic                ana_pwr_en,
    output logic                test_pd,
    output logic                cr_sel,
    output logic                ext_ld_done,
    output logic                sram_bypass,
    output logic [2:0]          lane_flip,
    output logic                ready,
    output logic                error
);
    localparam int T_MAX1 = (REXT_US > HOLD_US) ? REXT_US : HOLD_US;
    localparam int T_MAX  = (T_MAX1 > POLL_US) ? T_MAX1 : POLL_US;
    localparam int TMR_W  = $clog2(T_MAX + 1);
    localparam int TRY_W  = $clog2(POLL_TRIES + 1);
    localparam int B_MAX  = (SRAM_BURST > INIT_BURST) ? SRAM_BURST : INIT_BURST;
    localparam int BST_W  = $clog2(2 * B_MAX + 1);

    boot_state_e         state, nxt;
    logic [FW_IDX_W-1:0] idx;
    logic [TRY_W-1:0]    tries;
    logic [15:0]         swing_q;
    logic                rom_q, port_q;
    logic                accept, tmr_load, tmr_zero, bst_run, bst_tg, bst_last;
    logic                cal_ok, cal_last;
    logic [TMR_W-1:0]    tmr_val;
    logic [BST_W-1:0]    bst_half;
    logic [15:0]         cal_addr;

    assign accept   = start && (state == S_IDLE || state == S_DONE || state == S_FAILED);
    assign cal_ok   = cr_rdata[1];
    assign cal_last = (tries == TRY_W'(POLL_TRIES - 1));
    assign tmr_load = (state == S_POWER) || (state == S_REXT && tmr_zero) ||
                      (state == S_CAL_RD && cr_done && !cal_ok && !cal_last);
    assign tmr_val  = (state == S_POWER) ? TMR_W'(REXT_US) :
                      (state == S_REXT)  ? TMR_W'(HOLD_US) : TMR_W'(POLL_US);
    assign bst_run  = (state == S_SRAM_TG) || (state == S_INIT_TG);
    assign bst_half = (state == S_SRAM_TG) ? BST_W'(2 * SRAM_BURST) : BST_W'(2 * INIT_BURST);

    boot_us_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .tick(us_tick), .zero(tmr_zero));

    boot_clk_burst #(.W(BST_W)) u_bst (
        .clk(clk), .rst_n(rst_n), .run(bst_run), .half_len(bst_half),
        .tg(bst_tg), .last(bst_last));

    boot_lane_addr u_lane (.port(port_q), .base(CAL_BASE), .rx_addr(cal_addr));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_DONE, S_FAILED: if (start) nxt = S_RESET;
            S_RESET:    nxt = S_POWER;
            S_POWER:    nxt = S_REXT;
            S_REXT:     if (tmr_zero) nxt = S_HOLD;
            S_HOLD:     if (tmr_zero) nxt = S_SRAM_TG;
            S_SRAM_TG:  if (bst_last) nxt = S_SRAM_CHK;
            S_SRAM_CHK: nxt = !sram_init_done ? S_SRAM_TG : (rom_q ? S_CAL_RD : S_PRE0);
            S_PRE0:     if (cr_done) nxt = S_PRE1;
            S_PRE1:     if (cr_done) nxt = (fw_len == '0) ? S_LD_RISE : S_FW;
            S_FW:       if (cr_done && ({1'b0, idx} == fw_len - 1'b1)) nxt = S_LD_RISE;
            S_LD_RISE:  nxt = S_LD_HOLD;
            S_LD_HOLD:  nxt = S_INIT_TG;
            S_INIT_TG:  if (bst_last) nxt = S_INIT_CHK;
            S_INIT_CHK: nxt = init_done ? S_CAL_RD : S_INIT_TG;
            S_CAL_RD:   if (cr_done) nxt = cal_ok ? S_SW_RD : (cal_last ? S_FAILED : S_CAL_GAP);
            S_CAL_GAP:  if (tmr_zero) nxt = S_CAL_RD;
            S_SW_RD:    if (cr_done) nxt = S_SW_WR;
            S_SW_WR:    if (cr_done) nxt = S_DONE;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            idx     <= '0;
            tries   <= '0;
            swing_q <= '0;
            rom_q   <= 1'b0;
            port_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                idx    <= '0;
                tries  <= '0;
                rom_q  <= use_rom;
                port_q <= port_sel;
            end
            if (state == S_FW && cr_done) idx <= idx + 1'b1;
            if (state == S_CAL_RD && cr_done && !cal_ok) tries <= tries + 1'b1;
            if (state == S_SW_RD && cr_done) swing_q <= cr_rdata;
        end
    end

    // Registered control and status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_rst     <= 1'b0;
            lane0_rst   <= 1'b0;
            dp_tx_dis   <= '0;
            dp_tx_rst   <= '0;
            ana_pwr_en  <= 1'b0;
            test_pd     <= 1'b1;
            cr_sel      <= 1'b0;
            ext_ld_done <= 1'b0;
            sram_bypass <= 1'b0;
            lane_flip   <= '0;
            ready       <= 1'b0;
            error       <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE, S_FAILED: if (start) begin
                    ready <= 1'b0;
                    error <= 1'b0;
                end
                S_RESET: begin
                    phy_rst   <= 1'b1;
                    lane0_rst <= 1'b1;
                    dp_tx_dis <= '1;
                    dp_tx_rst <= '1;
                end
                S_POWER: begin
                    ana_pwr_en  <= 1'b1;
                    test_pd     <= 1'b0;
                    cr_sel      <= 1'b1;
                    ext_ld_done <= 1'b0;
                    sram_bypass <= rom_q;
                end
                S_REXT: if (tmr_zero) lane_flip <= port_q ? FLIP_PORT1 : 3'd0;
                S_HOLD: if (tmr_zero) begin
                    phy_rst   <= 1'b0;
                    lane0_rst <= 1'b0;
                end
                S_LD_RISE: ext_ld_done <= 1'b1;
                S_CAL_RD:  if (cr_done && !cal_ok && cal_last) error <= 1'b1;
                S_SW_WR:   if (cr_done) ready <= 1'b1;
                default: ;
            endcase
        end
    end

    // CR port and clock drive
    always_comb begin
        cr_req   = 1'b0;
        cr_we    = 1'b0;
        cr_addr  = '0;
        cr_wdata = '0;
        unique case (state)
            S_PRE0:  begin cr_req = 1'b1; cr_we = 1'b1; cr_addr = PRELOAD_A0; cr_wdata = PRELOAD_VAL; end
            S_PRE1:  begin cr_req = 1'b1; cr_we = 1'b1; cr_addr = PRELOAD_A1; cr_wdata = PRELOAD_VAL; end
            S_FW:    begin cr_req = 1'b1; cr_we = 1'b1; cr_addr = fw_addr;    cr_wdata = fw_data;     end
            S_CAL_RD: begin cr_req = 1'b1; cr_addr = cal_addr; end
            S_SW_RD:  begin cr_req = 1'b1; cr_addr = SWING_ADDR; end
            S_SW_WR: begin
                cr_req   = 1'b1;
                cr_we    = 1'b1;
                cr_addr  = SWING_ADDR;
                cr_wdata = (swing_q & ~SWING_CLR) | SWING_SET;
            end
            default: ;
        endcase
    end

    assign fw_idx = idx;
    assign cr_clk = bst_tg || (state == S_LD_RISE) || (state == S_LD_HOLD);

    // Assertions
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_req && !cr_done) |=> (cr_req && $stable(cr_addr) && $stable(cr_we) && $stable(cr_wdata)));
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n) !(ready && error));
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready);
    a_r3_release_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> $fell(lane0_rst));
    a_r6_load_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_ld_done) |-> cr_clk);
    a_r7_rom_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_bypass && cr_req && cr_we) |-> (cr_addr == SWING_ADDR));
    a_r7_rom_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        sram_bypass |-> !ext_ld_done);
    a_r8_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_W'(POLL_TRIES));
endmodule

// File: tb/sim_phy_boot_seq.sv
module sim_phy_boot_seq;
    localparam int CLK_P  = 10;
    localparam int REXT   = 10;
    localparam int HOLD   = 20;
    localparam int POLL   = 5;
    localparam int TRIES  = 4;
    localparam int SB     = 10;
    localparam int IB     = 8;
    localparam int IW     = 4;

    logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, start = 1'b0, use_rom = 1'b0, port_sel = 1'b0;
    logic [IW:0]   fw_len = '0;
    logic [IW-1:0] fw_idx;
    logic [15:0]   fw_addr, fw_data, cr_addr, cr_wdata;
    logic [15:0]   cr_rdata = '0;
    logic cr_req, cr_we, cr_clk, phy_rst, lane0_rst, ana_pwr_en, test_pd, cr_sel;
    logic ext_ld_done, sram_bypass, ready, error;
    logic cr_done = 1'b0, sram_init_done = 1'b0, init_done = 1'b0;
    logic [3:0] dp_tx_dis, dp_tx_rst;
    logic [2:0] lane_flip;

    int nchk = 0, nfail = 0, tick_cnt = 0;
    int nlog = 0, cal_reads = 0, cal_pass_at = 0;
    int rises_all = 0, rises_ld = 0, sram_pulses = 0, s_need = 1, i_need = 1;
    int rst_rise_t = 0, rst_fall_t = 0;
    bit reported = 0;
    logic        log_we[64];
    logic [15:0] log_addr[64];
    logic [15:0] log_data[64];
    int          log_tick[64];

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] fa(input int i); return 16'h1000 + 16'(i * 3); endfunction
    function automatic logic [15:0] fd(input int i); return 16'hA5A5 ^ 16'(i << 4); endfunction
    assign fw_addr = fa(int'(fw_idx));
    assign fw_data = fd(int'(fw_idx));

    phy_boot_seq #(.REXT_US(REXT), .HOLD_US(HOLD), .POLL_US(POLL), .POLL_TRIES(TRIES),
                   .SRAM_BURST(SB), .INIT_BURST(IB), .FW_IDX_W(IW), .DP_LANES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .use_rom(use_rom),
        .port_sel(port_sel), .fw_len(fw_len), .fw_idx(fw_idx), .fw_addr(fw_addr),
        .fw_data(fw_data), .cr_req(cr_req), .cr_we(cr_we), .cr_addr(cr_addr),
        .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .cr_done(cr_done), .cr_clk(cr_clk),
        .sram_init_done(sram_init_done), .init_done(init_done), .phy_rst(phy_rst),
        .lane0_rst(lane0_rst), .dp_tx_dis(dp_tx_dis), .dp_tx_rst(dp_tx_rst),
        .ana_pwr_en(ana_pwr_en), .test_pd(test_pd), .cr_sel(cr_sel),
        .ext_ld_done(ext_ld_done), .sram_bypass(sram_bypass), .lane_flip(lane_flip),
        .ready(ready), .error(error));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        end
        $finish;
    endtask

    // Microsecond tick: one cycle in four
    initial forever begin
        repeat (3) @(negedge clk);
        us_tick = 1'b1;
        tick_cnt++;
        @(negedge clk);
        us_tick = 1'b0;
    end

    // PHY status model: readiness after a number of CR clock pulses
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (cr_clk && !prev) begin
                rises_all++;
                if (ext_ld_done) rises_ld++;
                else sram_pulses++;
            end
            prev = cr_clk;
            sram_init_done = (rises_all >= s_need);
            init_done      = (rises_ld >= i_need);
        end
    end

    // Reset window monitor
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (phy_rst && !prev) rst_rise_t = tick_cnt;
            if (!phy_rst && prev) rst_fall_t = tick_cnt;
            prev = phy_rst;
        end
    end

    // CR port responder
    initial forever begin
        @(negedge clk);
        if (cr_req && rst_n) begin
            logic [15:0] rd;
            rd = 16'h0000;
            if (nlog < 64) begin
                log_we[nlog] = cr_we; log_addr[nlog] = cr_addr;
                log_data[nlog] = cr_wdata; log_tick[nlog] = tick_cnt;
            end
            nlog++;
            if (!cr_we && cr_addr == 16'h0022) rd = 16'h0305;
            else if (!cr_we) begin
                cal_reads++;
                if (cal_pass_at != 0 && cal_reads >= cal_pass_at) rd = 16'h0002;
                else rd = 16'hFFFD;
            end
            repeat (2) @(negedge clk);
            cr_rdata = rd;
            cr_done  = 1'b1;
            @(negedge clk);
            cr_done  = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired before the sequence finished");
        report();
    end

    task automatic run_one(input bit rom, input bit port, input int len, input int sn,
                           input int in_, input int pass, input bit mid);
        int exp_n, p, nreads, bursts;
        bit injected, pass_ok;
        logic [15:0] cal_a;
        injected = 0;
        use_rom = rom; port_sel = port; fw_len = (IW+1)'(len);
        s_need = sn; i_need = in_; cal_pass_at = pass;
        nlog = 0; cal_reads = 0; rises_all = 0; rises_ld = 0; sram_pulses = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R2: controls after the reset and power states
        repeat (2) @(negedge clk);
        chk(phy_rst && lane0_rst, "R2 resets asserted", {phy_rst, lane0_rst}, 3);
        chk(dp_tx_dis == 4'hF && dp_tx_rst == 4'hF, "R2 DP lanes parked", {dp_tx_dis, dp_tx_rst}, 8'hFF);
        chk(ana_pwr_en && !test_pd && cr_sel && !ext_ld_done, "R2 power controls",
            {ana_pwr_en, test_pd, cr_sel, ext_ld_done}, 4'b1010);
        chk(sram_bypass == rom, "R2 boot mode select", sram_bypass, rom);
        while (!(ready || error)) begin
            @(negedge clk);
            if (mid && !injected && nlog == 3) begin
                injected = 1; start = 1'b1;
                @(negedge clk); start = 1'b0;
            end
        end
        pass_ok = (pass != 0 && pass <= TRIES);
        chk(ready == pass_ok && error == !pass_ok, "R8/R9 final status", {ready, error}, {pass_ok, !pass_ok});
        chk(lane_flip == (port ? 3'd4 : 3'd0), "R3 lane flip", lane_flip, port ? 4 : 0);
        chk(!phy_rst && !lane0_rst, "R3 resets released", {phy_rst, lane0_rst}, 0);
        chk(rst_fall_t - rst_rise_t >= REXT + HOLD, "R3 reset window ticks", rst_fall_t - rst_rise_t, REXT + HOLD);
        bursts = (sn + SB - 1) / SB; if (bursts < 1) bursts = 1;
        chk(sram_pulses == SB * bursts + (rom ? 0 : 1), "R4 SRAM wait pulses", sram_pulses, SB * bursts + (rom ? 0 : 1));
        if (rom) begin
            chk(!ext_ld_done && rises_ld == 0, "R7 no load hand-over", rises_ld, 0);
        end else begin
            bursts = (in_ + IB - 1) / IB; if (bursts < 1) bursts = 1;
            chk(ext_ld_done, "R6 load done set", ext_ld_done, 1);
            chk(rises_ld == IB * bursts, "R6 init wait pulses", rises_ld, IB * bursts);
        end
        // Expected CR transaction log
        nreads = pass_ok ? pass : TRIES;
        exp_n  = (rom ? 0 : 2 + len) + nreads + (pass_ok ? 2 : 0);
        chk(nlog == exp_n, "R5/R7/R8 CR access count", nlog, exp_n);
        cal_a = 16'h303E + (port ? 16'h0200 : 16'h0100);
        p = 0;
        if (!rom && nlog == exp_n) begin
            chk(log_we[0] && log_addr[0] == 16'h31C5 && log_data[0] == 16'h8000, "R5 preload 0", log_addr[0], 16'h31C5);
            chk(log_we[1] && log_addr[1] == 16'h32C5 && log_data[1] == 16'h8000, "R5 preload 1", log_addr[1], 16'h32C5);
            p = 2;
            for (int i = 0; i < len; i++) begin
                chk(log_we[p] && log_addr[p] == fa(i) && log_data[p] == fd(i), "R5 table entry", log_data[p], fd(i));
                p++;
            end
        end
        if (nlog == exp_n) begin
            for (int i = 0; i < nreads; i++) begin
                chk(!log_we[p] && log_addr[p] == cal_a, "R8 poll address", log_addr[p], cal_a);
                if (i > 0) chk(log_tick[p] - log_tick[p-1] >= POLL, "R8 poll spacing",
                               log_tick[p] - log_tick[p-1], POLL);
                p++;
            end
            if (pass_ok) begin
                chk(!log_we[p] && log_addr[p] == 16'h0022, "R9 swing read", log_addr[p], 16'h0022);
                chk(log_we[p+1] && log_addr[p+1] == 16'h0022 && log_data[p+1] == 16'h03F5,
                    "R9 swing write", log_data[p+1], 16'h03F5);
            end
        end
        // R10: status holds without a new start
        repeat (20) @(negedge clk);
        chk(ready == pass_ok && error == !pass_ok, "R10 sticky status", {ready, error}, {pass_ok, !pass_ok});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!ready && !error && !cr_req, "R1 status idle", {ready, error, cr_req}, 0);
        chk(!phy_rst && !lane0_rst && !ext_ld_done && !cr_clk, "R1 controls idle",
            {phy_rst, lane0_rst, ext_ld_done, cr_clk}, 0);
        chk(test_pd, "R1 test power-down", test_pd, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_one(0, 0, 3, 1, 8, 1, 0);
        run_one(0, 1, 0, 10, 9, 2, 0);
        run_one(1, 0, 0, 11, 1, TRIES, 0);
        run_one(1, 1, 0, 25, 1, 0, 0);
        run_one(0, 1, 15, 20, 1, 3, 1);
        run_one(0, 0, 1, 3, 17, 0, 0);
        report();
    end
endmodule